// File: doc/BRIEF.md
# I2S Stereo Audio Receiver

This block turns a three-wire stereo audio stream (bit clock, word clock, serial data) into parallel PCM samples inside the system clock domain. All three serial lines pass through two-flop synchronizers, and the bit-clock edges are found there. The system clock must run at least four times faster than the bit clock. On each sampling edge the receiver checks whether the word clock has toggled. A falling word clock starts a left slot and a rising one starts a right slot. The receiver then collects the sample most significant bit first.

Software sets up the block through a small set of static inputs:
- a two-bit format selector, where only I2S is accepted;
- an extra bit delay (offset) ahead of the MSB;
- one of four word lengths;
- an option to sample on the opposite bit-clock edge;
- the number of bit clocks per frame.

This configuration only feeds a consistency check. The check raises an error flag when the word cannot fit in a channel or in the frame after the offset. Each finished word appears MSB-aligned on a 32-bit output, together with a left/right tag and a one-cycle strobe.

Top module: `i2s_rx_core`

## Requirements
- R1: `cfg_fmt` = 2'b00 enables I2S reception. Any other value produces no `smp_valid` pulse and drives `cfg_err` high.
- R2: With offset 0, the MSB is the data bit on the second sampling edge after the word clock changes. The bit on the edge where the change is first seen does not belong to the new word. Each later edge carries the next lower bit. A word that starts after a falling word clock is tagged `smp_right`=0, and one that starts after a rising word clock is tagged `smp_right`=1.
- R3: An offset of K moves the MSB K sampling edges later than its offset-0 position.
- R4: `cfg_wlen` selects 16 (2'b00), 20 (2'b01), 24 (2'b10) or 32 (2'b11) bits. The word sits in `smp_data[31:32-L]` with the lower bits zero. Bits that arrive after the LSB, up to the next word-clock change, are ignored.
- R5: With `cfg_bclk_inv`=0, data is sampled on rising bit-clock edges. With `cfg_bclk_inv`=1, it is sampled on falling edges.
- R6: `smp_valid` is a one-cycle pulse, issued once for each completed word. No word is produced before the first word-clock change seen after reset.
- R7: If the word clock changes before all bits of a word have arrived, that partial word is dropped and the new slot starts from its first bit.
- R8: One clock after the configuration is applied, `cfg_err` is high when either of these holds:
  - `cfg_frame_bits`/2 < L;
  - `cfg_offset` + L > `cfg_frame_bits`.
- R9: While `rst_n` is low, `smp_valid`, `smp_right`, `smp_data` and `cfg_err` are all 0.
- R10: If a word's LSB arrives on the same sampling edge where a word-clock change is detected (offset + L equals the slot length), the word completes under the old channel tag and the new slot starts on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock |
| lrclk_in | input | 1 | Word clock (0 = left slot, 1 = right slot) |
| sdata_in | input | 1 | Serial data, MSB first |
| cfg_fmt | input | 2 | Format select, 2'b00 = I2S |
| cfg_offset | input | 8 | Extra bit delay before the MSB |
| cfg_wlen | input | 2 | Word length code |
| cfg_bclk_inv | input | 1 | Sample on the falling bit-clock edge |
| cfg_frame_bits | input | 9 | Bit clocks per stereo frame |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_right | output | 1 | Channel tag of the sample (1 = right) |
| smp_data | output | 32 | MSB-aligned sample |
| cfg_err | output | 1 | Configuration error flag |

## Verification
The critical coincidence is a word's LSB capture landing on the very sampling edge where the word clock toggles. In that single cycle the deserializer must finish the old word under the old channel tag and also start the next slot. The bench provokes this by choosing slot lengths equal to offset plus word length: 32-bit words in 32-clock slots, and 16-bit words behind an offset of 16. The random configurations also hit it whenever the drawn slot length equals that sum. Every output word is judged against a queue built by a bench model of the serial stream, so a merged, lost or mistagged word shows up as a mismatch or as a missing or unexpected strobe.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    parameter int unsigned SMP_W = 32;
    localparam int unsigned CNT_W = $clog2(SMP_W + 1);

    localparam logic [1:0] FMT_I2S = 2'b00;

    typedef enum logic [1:0] {
        WL16 = 2'b00,
        WL20 = 2'b01,
        WL24 = 2'b10,
        WL32 = 2'b11
    } wlen_e;

    function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] sel);
        logic [CNT_W-1:0] r;
        case (wlen_e'(sel))
            WL16:    r = CNT_W'(16);
            WL20:    r = CNT_W'(20);
            WL24:    r = CNT_W'(24);
            default: r = CNT_W'(32);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/i2s_rx_cfgchk.sv
module i2s_rx_cfgchk
    import i2s_rx_pkg::*;
#(
    parameter int unsigned OFS_W = 8,
    parameter int unsigned FRM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_fmt,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic [1:0]       cfg_wlen,
    input  logic [FRM_W-1:0] cfg_frame_bits,
    output logic             err
);

    localparam int unsigned SUM_W = ((OFS_W > FRM_W) ? OFS_W : FRM_W) + 2;

    logic [SUM_W-1:0] need_bits;
    logic [SUM_W-1:0] frame_x;
    logic [SUM_W-1:0] half_x;
    logic [SUM_W-1:0] wl_x;
    logic             err_d;
    logic             err_q;

    always_comb begin
        wl_x      = SUM_W'(wlen_bits(cfg_wlen));
        need_bits = SUM_W'(cfg_offset) + wl_x;
        frame_x   = SUM_W'(cfg_frame_bits);
        half_x    = SUM_W'(cfg_frame_bits >> 1);
        err_d     = (cfg_fmt != FMT_I2S) || (half_x < wl_x) || (need_bits > frame_x);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;

    // R8: offset plus word length beyond the frame is flagged on the next clock
    a_r8_offset_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (need_bits > frame_x) |=> err_q);

    // R1: a non-I2S format is flagged on the next clock
    a_r1_fmt_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fmt != FMT_I2S) |=> err_q);

endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
#(
    parameter int unsigned OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic             lr_s,
    input  logic             sd_s,
    input  logic [1:0]       cfg_fmt,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_bclk_inv,
    output logic             smp_valid,
    output logic             smp_right,
    output logic [SMP_W-1:0] smp_data
);

    typedef struct packed {
        logic             bclk_last;
        logic             seen;
        logic             lr_last;
        logic             run;
        logic             chan;
        logic [OFS_W-1:0] skip;
        logic [CNT_W-1:0] cnt;
        logic [SMP_W-1:0] sh;
        logic             vld;
        logic             vchan;
        logic [SMP_W-1:0] vdata;
    } deser_st_t;

    deser_st_t st_d;
    deser_st_t st_q;

    logic             samp_edge;
    logic             lr_change;
    logic [CNT_W-1:0] wl;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] pad_amt;
    logic [SMP_W-1:0] sh_next;
    logic             take_bit;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.bclk_last = bclk_s;

        wl        = wlen_bits(cfg_wlen);
        pad_amt   = CNT_W'(SMP_W) - wl;
        cnt_inc   = st_q.cnt + CNT_W'(1);
        sh_next   = {st_q.sh[SMP_W-2:0], sd_s};
        samp_edge = cfg_bclk_inv ? (!bclk_s && st_q.bclk_last)
                                 : (bclk_s && !st_q.bclk_last);
        lr_change = st_q.seen && (lr_s != st_q.lr_last);
        take_bit  = 1'b0;

        if (cfg_fmt != FMT_I2S) begin
            st_d.run  = 1'b0;
            st_d.seen = 1'b0;
        end else if (samp_edge) begin
            st_d.seen    = 1'b1;
            st_d.lr_last = lr_s;

            if (st_q.run && (st_q.skip == '0)) begin
                take_bit = lr_change ? (cnt_inc == wl) : 1'b1;
            end

            if (take_bit) begin
                st_d.sh  = sh_next;
                st_d.cnt = cnt_inc;
                if (cnt_inc == wl) begin
                    st_d.vld   = 1'b1;
                    st_d.vchan = st_q.chan;
                    st_d.vdata = sh_next << pad_amt;
                    st_d.run   = 1'b0;
                end
            end else if (st_q.run && (st_q.skip != '0)) begin
                st_d.skip = st_q.skip - OFS_W'(1);
            end

            if (lr_change) begin
                st_d.run  = 1'b1;
                st_d.chan = lr_s;
                st_d.skip = cfg_offset;
                st_d.cnt  = '0;
                st_d.sh   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_valid = st_q.vld;
    assign smp_right = st_q.vchan;
    assign smp_data  = st_q.vdata;

    // R6: the strobe never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);

    // R1: no strobe follows a cycle with a non-I2S format
    a_r1_fmt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fmt != FMT_I2S) |=> !smp_valid);

    // R4: a 16-bit word leaves the low half of the output clear
    a_r4_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ($past(cfg_wlen) == WL16)) |-> (smp_data[15:0] == '0));

    // R7: the bit count never passes the output width
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(SMP_W));

endmodule

// File: rtl/i2s_rx_core.sv
module i2s_rx_core
    import i2s_rx_pkg::*;
#(
    parameter int unsigned OFS_W       = 8,
    parameter int unsigned FRM_W       = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_in,
    input  logic             lrclk_in,
    input  logic             sdata_in,
    input  logic [1:0]       cfg_fmt,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_bclk_inv,
    input  logic [FRM_W-1:0] cfg_frame_bits,
    output logic             smp_valid,
    output logic             smp_right,
    output logic [SMP_W-1:0] smp_data,
    output logic             cfg_err
);

    localparam int unsigned N_LINES = 3;

    logic [N_LINES-1:0] lines_raw;
    logic [N_LINES-1:0] lines_s;

    assign lines_raw = {sdata_in, lrclk_in, bclk_in};

    i2s_rx_sync #(
        .W      (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lines_raw),
        .dout  (lines_s)
    );

    i2s_rx_deser #(
        .OFS_W (OFS_W)
    ) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_s       (lines_s[0]),
        .lr_s         (lines_s[1]),
        .sd_s         (lines_s[2]),
        .cfg_fmt      (cfg_fmt),
        .cfg_offset   (cfg_offset),
        .cfg_wlen     (cfg_wlen),
        .cfg_bclk_inv (cfg_bclk_inv),
        .smp_valid    (smp_valid),
        .smp_right    (smp_right),
        .smp_data     (smp_data)
    );

    i2s_rx_cfgchk #(
        .OFS_W (OFS_W),
        .FRM_W (FRM_W)
    ) u_cfgchk (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_fmt        (cfg_fmt),
        .cfg_offset     (cfg_offset),
        .cfg_wlen       (cfg_wlen),
        .cfg_frame_bits (cfg_frame_bits),
        .err            (cfg_err)
    );

endmodule

// File: tb/sim_i2s_rx_core.sv
`timescale 1ns/1ps
module sim_i2s_rx_core;

    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b1;
    logic        lrclk_in = 1'b1;
    logic        sdata_in = 1'b0;
    logic [1:0]  cfg_fmt = 2'b00;
    logic [7:0]  cfg_offset = 8'd0;
    logic [1:0]  cfg_wlen = 2'b00;
    logic        cfg_bclk_inv = 1'b0;
    logic [8:0]  cfg_frame_bits = 9'd64;
    logic        smp_valid;
    logic        smp_right;
    logic [31:0] smp_data;
    logic        cfg_err;

    int          n_tests = 0;
    int          n_fail = 0;
    int          rx_count = 0;
    int          exp_count = 0;
    string       cur_req = "R2";
    logic [31:0] exp_data[$];
    logic        exp_chan[$];
    logic        pend_bit = 1'b0;
    logic        pend_ok = 1'b0;

    always #2 clk = ~clk;

    i2s_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .sdata_in(sdata_in), .cfg_fmt(cfg_fmt), .cfg_offset(cfg_offset),
        .cfg_wlen(cfg_wlen), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_frame_bits(cfg_frame_bits), .smp_valid(smp_valid),
        .smp_right(smp_right), .smp_data(smp_data), .cfg_err(cfg_err)
    );

    function automatic int wl_of(input logic [1:0] c);
        case (c)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] align(input logic [31:0] w, input int wl);
        return w << (32 - wl);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // output monitor against the expected-word queue
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            rx_count++;
            if (exp_data.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL %s actual=unexpected word %h expected=no word", cur_req, smp_data);
            end else begin
                check(cur_req, smp_data, exp_data.pop_front());
                check(cur_req, {31'd0, smp_right}, {31'd0, exp_chan.pop_front()});
            end
        end
    end

    task automatic tx_bit(input logic ws, input logic d);
        @(posedge clk); #1;
        bclk_in  = cfg_bclk_inv ? 1'b1 : 1'b0;
        lrclk_in = ws;
        sdata_in = d;
        repeat (H) @(posedge clk);
        #1;
        bclk_in = cfg_bclk_inv ? 1'b0 : 1'b1;
        repeat (H - 1) @(posedge clk);
    endtask

    // one slot of n bit clocks; position 0 is the edge on which the change is seen
    task automatic run_slot(input logic ws, input int n, input logic [31:0] word, input logic want);
        int wl = wl_of(cfg_wlen);
        int off = int'(cfg_offset);
        if (want && (off + wl <= n)) begin
            exp_data.push_back(align(word, wl));
            exp_chan.push_back(ws);
            exp_count++;
        end
        for (int j = 0; j < n; j++) begin
            logic v;
            int k;
            v = 1'($urandom);
            if (j == 0 && pend_ok) v = pend_bit;
            k = j - 1 - off;
            if (want && k >= 0 && k < wl) v = word[wl - 1 - k];
            tx_bit(ws, v);
        end
        pend_ok  = want && (off + wl == n);
        pend_bit = word[0];
    endtask

    task automatic start_test(input string req, input logic [1:0] fmt, input logic [1:0] wlc,
                              input int off, input logic inv, input int frame);
        rst_n = 1'b0;
        cur_req = req;
        cfg_fmt = fmt;
        cfg_wlen = wlc;
        cfg_offset = 8'(off);
        cfg_bclk_inv = inv;
        cfg_frame_bits = 9'(frame);
        bclk_in = inv ? 1'b0 : 1'b1;
        lrclk_in = 1'b1;
        pend_ok = 1'b0;
        rx_count = 0;
        exp_count = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run_slot(1'b1, 4, 32'd0, 1'b0);
    endtask

    task automatic end_test();
        tx_bit(~lrclk_in, pend_ok ? pend_bit : 1'b0);
        repeat (20) @(posedge clk);
        #1;
        check({cur_req, " word count"}, 32'(rx_count), 32'(exp_count));
    endtask

    function automatic logic [31:0] rword(input int wl);
        logic [31:0] w = $urandom;
        return (wl == 32) ? w : (w & ((32'd1 << wl) - 32'd1));
    endfunction

    task automatic frames(input int nframes, input int n);
        int wl = wl_of(cfg_wlen);
        for (int f = 0; f < nframes; f++) begin
            run_slot(1'b0, n, rword(wl), 1'b1);
            run_slot(1'b1, n, rword(wl), 1'b1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R9: reset values
        check("R9 valid", {31'd0, smp_valid}, 32'd0);
        check("R9 data", smp_data, 32'd0);
        check("R9 err", {31'd0, cfg_err}, 32'd0);

        // R2 R4 R6: 16-bit words, standard delay
        start_test("R2", 2'b00, 2'b00, 0, 1'b0, 64);
        frames(3, 32);
        end_test();

        // R10: 32-bit words fill the slot, LSB on the word-clock edge
        start_test("R10", 2'b00, 2'b11, 0, 1'b0, 64);
        frames(3, 32);
        end_test();

        // R3: offset of 2 with 24-bit words
        start_test("R3", 2'b00, 2'b10, 2, 1'b0, 64);
        frames(3, 32);
        end_test();

        // R5: inverted bit clock, 20-bit words, offset 1
        start_test("R5", 2'b00, 2'b01, 1, 1'b1, 48);
        frames(3, 24);
        end_test();

        // R10 with offset: 16 + 16 fills a 32-clock slot
        start_test("R10", 2'b00, 2'b00, 16, 1'b0, 64);
        frames(2, 32);
        end_test();

        // R7: a short left slot drops its partial word
        start_test("R7", 2'b00, 2'b10, 0, 1'b0, 64);
        run_slot(1'b0, 32, rword(24), 1'b1);
        run_slot(1'b1, 32, rword(24), 1'b1);
        run_slot(1'b0, 16, rword(24), 1'b1);
        run_slot(1'b1, 32, rword(24), 1'b1);
        run_slot(1'b0, 32, rword(24), 1'b1);
        end_test();

        // R8: configuration checks
        start_test("R8", 2'b00, 2'b11, 0, 1'b0, 48);
        repeat (3) @(posedge clk); #1;
        check("R8 channel too short", {31'd0, cfg_err}, 32'd1);
        cfg_frame_bits = 9'd64; cfg_wlen = 2'b10; cfg_offset = 8'd40;
        repeat (3) @(posedge clk); #1;
        check("R8 offset at limit", {31'd0, cfg_err}, 32'd0);
        cfg_offset = 8'd41;
        repeat (3) @(posedge clk); #1;
        check("R8 offset over limit", {31'd0, cfg_err}, 32'd1);
        cfg_offset = 8'd0;
        repeat (3) @(posedge clk); #1;
        check("R8 legal", {31'd0, cfg_err}, 32'd0);

        // R1: unsupported format gives no words and raises the flag
        start_test("R1", 2'b01, 2'b00, 0, 1'b0, 64);
        for (int f = 0; f < 2; f++) begin
            run_slot(1'b0, 32, rword(16), 1'b0);
            run_slot(1'b1, 32, rword(16), 1'b0);
        end
        check("R1 err", {31'd0, cfg_err}, 32'd1);
        end_test();

        // random legal configurations (R2 R3 R4 R5 R10)
        for (int t = 0; t < 6; t++) begin
            logic [1:0] wlc = 2'($urandom);
            int wl = wl_of(wlc);
            int n = wl + int'($urandom % 9);
            int off = int'($urandom % (n - wl + 1));
            start_test("R4", 2'b00, wlc, off, 1'($urandom), 2 * n);
            frames(2, n);
            end_test();
            check("R8 random legal", {31'd0, cfg_err}, 32'd0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule